// File: doc/BRIEF.md
# Latching Interrupt Capture Bank

A bank of eight interrupt channels meant for events that must be caught even while the register clock is stopped, such as power-down indications. Each channel owns a sticky capture flag. The flag is set asynchronously, by the input itself, whenever the input sits at the level that channel's polarity bit selects. No clock edge is involved in setting it. The flag is then passed through a two-flop synchronizer into the register clock domain, where it appears as raw status.

Software works through a small 32-bit register window. It sets per-channel enable, polarity and mode bits. It reads raw and enabled (masked) status, and writes ones to discard captured events. Only level detection exists in hardware. Software that wants edges flips the polarity bit after each event. The interrupt output is the OR of the masked status.

Top module: `latch_irq_bank`

## Requirements
- R1: After reset, the enable (0x00), raw (0x04), masked (0x08), polarity (0x10) and mode (0x14) words read 0, and `irq` is 0.
- R2: A channel's flag sets when its input equals the active level: polarity bit 0 means active-high, 1 means active-low. This holds even for a pulse that contains no clock edge. The flag shows in the raw word (bit i = channel i) after the second rising clock edge that follows the input change or the polarity write.
- R3: A captured flag stays set after its input returns to the inactive level, until it is cleared.
- R4: Writing a word with bit i = 1 to offset 0x0C discards channel i's flag, and raw bit i reads 0 after the second rising edge after the write. Bits written 0 leave their channels untouched, and offset 0x0C always reads 0.
- R5: A clear written while the input is still at its active level has no effect: the flag remains set.
- R6: The masked word at 0x08 equals raw AND enable. Enable does not gate capture, so raw still records events on disabled channels.
- R7: `irq` is 1 exactly when the masked word is non-zero.
- R8: Polarity (0x10) and mode (0x14) are read/write, one bit per channel. Mode bits are stored only and do not change detection.
- R9: Bits 31:8 of every read are 0. Offsets 0x18 and 0x1C read 0. Writes to the raw and masked offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the accessed word |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| evt_in | input | 8 | Channel event inputs, may be asynchronous |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect on the rising edge that samples `bus_we`, and a read of that word at the following falling edge already shows the new value. Changes to raw and masked status, and to `irq`, come two rising edges after an input change, a polarity write or a clear write, because of the synchronizer. The driver therefore lets two rising edges pass before it queues an expected value. The monitor samples 4 ns after the falling edge on which the driver set up the read, well away from the next rising edge. Short pulses are placed wholly between two clock edges, to show that capture needs no clock.

// File: rtl/latch_irq_bank.sv
module latch_irq_bank #(
  parameter int CH     = 8,
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [CH-1:0]     evt_in,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_RAW  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_MSK  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFS_POL  = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(5'h14);

  logic [CH-1:0] en_q, pol_q, mode_q, raw_q, flag_q;
  wire  [CH-1:0] wbits = bus_wdata[CH-1:0];
  wire           unused_hi = ^bus_wdata[DW-1:CH];
  wire           clr_wr = bus_we && (bus_addr == OFS_CLR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == OFS_EN)   en_q   <= wbits;
      if (bus_addr == OFS_POL)  pol_q  <= wbits;
      if (bus_addr == OFS_MODE) mode_q <= wbits;
    end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    wire hit = evt_in[i] ^ pol_q[i];
    logic [SYNC-1:0] sh;

    always_ff @(posedge clk or negedge rst_n or posedge hit)
      if (!rst_n)                 flag_q[i] <= 1'b0;
      else if (hit)               flag_q[i] <= 1'b1;
      else if (clr_wr && wbits[i]) flag_q[i] <= 1'b0;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC-2:0], flag_q[i]};

    assign raw_q[i] = sh[SYNC-1];
  end

  wire [CH-1:0] masked = raw_q & en_q;
  assign irq = |masked;

  logic [CH-1:0] rd_val;
  always_comb begin
    case (bus_addr)
      OFS_EN:   rd_val = en_q;
      OFS_RAW:  rd_val = raw_q;
      OFS_MSK:  rd_val = masked;
      OFS_POL:  rd_val = pol_q;
      OFS_MODE: rd_val = mode_q;
      default:  rd_val = '0;
    endcase
  end
  assign bus_rdata = {{(DW-CH){unused_hi & 1'b0}}, rd_val};
endmodule

module latch_irq_bank_chk #(
  parameter int CH     = 8,
  parameter int ADDR_W = 5,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic [CH-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic [CH-1:0]     evt_in,
  input logic              irq,
  input logic [CH-1:0]     raw_q,
  input logic [CH-1:0]     en_q,
  input logic [CH-1:0]     pol_q
);
  logic [2:0]    age;
  logic [CH-1:0] clr_d1, clr_d2, clr_d3, hit_d1, hit_d2, raw_prev;
  wire  [CH-1:0] clr_now = (we && addr == ADDR_W'(5'h0C)) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      age <= '0;
      {clr_d1, clr_d2, clr_d3, hit_d1, hit_d2, raw_prev} <= '0;
    end else begin
      if (age != 3'd7) age <= age + 3'd1;
      clr_d1 <= clr_now;
      clr_d2 <= clr_d1;
      clr_d3 <= clr_d2;
      hit_d1 <= evt_in ^ pol_q;
      hit_d2 <= hit_d1;
      raw_prev <= raw_q;
    end

  // R2
  capture_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd3) |-> ((hit_d2 & ~raw_q) == '0));
  // R3
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd4) |-> ((raw_prev & ~raw_q & ~clr_d3) == '0));
  // R4
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(5'h0C)) |-> (rdata == '0));
  // R6
  masked_within_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(5'h08)) |-> ((rdata[CH-1:0] & ~en_q) == '0));
  // R7
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:CH] == '0);
endmodule

bind latch_irq_bank latch_irq_bank_chk #(.CH(CH), .ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
  .wdata(bus_wdata[CH-1:0]), .rdata(bus_rdata), .evt_in(evt_in), .irq(irq),
  .raw_q(raw_q), .en_q(en_q), .pol_q(pol_q)
);

// File: tb/latch_irq_bank_tb.sv
module latch_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_in = '0;
  logic        irq;

  always #10 clk = ~clk;

  latch_irq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  initial forever begin
    item_t it;
    logic [31:0] act;
    wait (sbq.size() != 0);
    #4;
    it = sbq.pop_front();
    act = it.is_irq ? {31'b0, irq} : bus_rdata;
    n_chk++;
    if (act !== it.exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
    end
  end

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a;
    sbq.push_back('{1'b0, e, t});
    @(posedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    sbq.push_back('{1'b1, {31'b0, e}, t});
    @(posedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_evt(input logic [7:0] v);
    @(negedge clk);
    evt_in = v;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk);
    evt_in[ch] = 1'b1;
    #3 evt_in[ch] = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    tick(3);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk_rd(5'h00, 32'h0, "R1 enable");
    chk_rd(5'h04, 32'h0, "R1 raw");
    chk_rd(5'h08, 32'h0, "R1 masked");
    chk_rd(5'h10, 32'h0, "R1 polarity");
    chk_rd(5'h14, 32'h0, "R1 mode");
    chk_irq(1'b0, "R1 irq");
    // R2 short pulse with no clock edge, active-high
    pulse(0); tick(2);
    chk_rd(5'h04, 32'h01, "R2 pulse capture");
    chk_rd(5'h08, 32'h00, "R6 disabled channel masked");
    chk_irq(1'b0, "R7 irq without enable");
    // R3 sticky
    tick(3);
    chk_rd(5'h04, 32'h01, "R3 flag held");
    // R6 R7 enable
    wr(5'h00, 32'h01);
    chk_rd(5'h08, 32'h01, "R6 masked after enable");
    chk_irq(1'b1, "R7 irq asserted");
    // R8 polarity: ch7 active-low while input low
    wr(5'h10, 32'h80); tick(2);
    chk_rd(5'h04, 32'h81, "R2 active-low capture");
    chk_rd(5'h10, 32'h80, "R8 polarity readback");
    // R4 clear one channel
    set_evt(8'h80);
    wr(5'h0C, 32'h80); tick(2);
    chk_rd(5'h04, 32'h01, "R4 selective clear");
    chk_rd(5'h0C, 32'h0, "R4 clear offset reads zero");
    // R5 clear while active
    set_evt(8'h88); tick(2);
    chk_rd(5'h04, 32'h09, "R2 level capture ch3");
    wr(5'h0C, 32'h08); tick(2);
    chk_rd(5'h04, 32'h09, "R5 clear ignored while active");
    set_evt(8'h80);
    wr(5'h0C, 32'h08); tick(2);
    chk_rd(5'h04, 32'h01, "R4 clear after release");
    // R8 mode stored, no effect
    wr(5'h14, 32'hFF);
    chk_rd(5'h14, 32'hFF, "R8 mode readback");
    pulse(5); tick(2);
    chk_rd(5'h04, 32'h21, "R8 mode leaves capture");
    // R9 upper bits, read-only offsets, unmapped
    wr(5'h00, 32'hFFFF_FFFF);
    chk_rd(5'h00, 32'hFF, "R9 upper bits zero");
    wr(5'h04, 32'h0); wr(5'h08, 32'h0); tick(2);
    chk_rd(5'h04, 32'h21, "R9 raw write ignored");
    chk_rd(5'h18, 32'h0, "R9 unmapped 0x18");
    chk_rd(5'h1C, 32'h0, "R9 unmapped 0x1C");
    // R6 R7 enable selection
    wr(5'h00, 32'h20);
    chk_rd(5'h08, 32'h20, "R6 masked subset");
    chk_irq(1'b1, "R7 irq on ch5");
    wr(5'h00, 32'h00);
    chk_irq(1'b0, "R7 irq off when disabled");
    chk_rd(5'h04, 32'h21, "R6 capture kept while disabled");
    // R4 clear all
    wr(5'h0C, 32'hFF); tick(2);
    chk_rd(5'h04, 32'h00, "R4 clear all");
    wait (sbq.size() == 0);
    #10;
    done = 1;
    finish_run();
  end
endmodule